// File: doc/BRIEF.md
# Delay-Line Edge Search Lane Tracker

This block keeps the per-lane bookkeeping for a delay-line edge search used in per-bit deskew training of a memory data interface. The search engine runs outside the block. It sweeps a delay line and produces one status word per data bit. The host feeds each word to the block, tagged with its lane. For every active lane the block classifies the outcome and keeps the smallest and largest adjusted edge codes. It derives a lane shift value and a lock flag from them.

A run starts with a `start` pulse that latches the direction mode (receive or transmit) and the active-lane mask. The search has up to three passes: an initial pass, an extended pass for lanes whose result sat on the boundary, and a secondary pass in the reversed direction for any lane still unlocked. The block tells the host which pass must run next, with the sweep direction, iteration count and start value. The host marks the end of each pass with `pass_end`. When the last needed pass has ended, the block pulses `done`. The state, shift and lock of any lane can be read at any time through an indexed status port.

Top module: `lane_edge_tracker`

## Requirements
- R1: On `start` every lane takes state code 3 and is locked. Its low tracker is seeded with 31 (receive) or 63 (transmit) and its high tracker with 0. `pass_next` becomes 1 (initial pass), with `search_up` = 0 and 31 iterations in receive mode, or `search_up` = 1 and 63 iterations in transmit mode.
- R2: A status word counts as passing only when bit 25 is 1. Its edge code is bits [4:0] in receive mode and bits [5:0] in transmit mode; all other bits are ignored.
- R3: In the initial pass, a lane in state 3 that receives a failing word moves to state 1 (failed) and unlocks. A passing word whose code is 31 (receive) or 0 (transmit) moves it to state 4 and unlocks it. Further words to a lane that has left state 3 are ignored.
- R4: A passing, non-boundary code is adjusted by +1 in receive mode or by -1 in transmit mode (0 stays 0). It is then folded into the lane's low and high trackers. The lane shift value is the high tracker in receive mode and the low tracker in transmit mode.
- R5: On entry to the extended pass, lanes in state 4 have their trackers reseeded. In that pass only state-4 lanes take words. A passing non-boundary word locks the lane and is folded in. A failing or boundary word moves the lane to state 2 and unlocks it, and later words to that lane are ignored.
- R6: On entry to the secondary pass, every active unlocked lane moves to state 2 and its trackers are reseeded. Only those lanes take words in that pass. A failing word moves the lane to state 1 and stops it. At the end of the pass the lane locks only if exactly 8 passing words were counted.
- R7: Pass order is fixed. After the initial pass comes the extended pass if any active lane is in state 4, otherwise the secondary pass if any active lane is unlocked, otherwise completion. After the extended pass comes the secondary pass if any active lane is unlocked, otherwise completion. The secondary pass is always followed by completion. Completion raises `done` for one cycle, and `pass_next` returns to 0 (idle).
- R8: During the secondary pass (`pass_next` = 3) the sweep runs opposite to the initial direction with 31 iterations. `search_first` is 0 when sweeping up and the iteration count when sweeping down.
- R9: Lanes outside the active mask ignore all words and take no part in pass decisions. A lane takes at most 8 words per pass; extra words are ignored.
- R10: `need_secondary` is 1 exactly when at least one active lane is unlocked.
- R11: `rd_state`, `rd_shift` and `rd_lock` show the lane selected by `rd_lane` in the same cycle. State codes are 1 failed, 2 secondary, 3 initial, 4 extended. `pass_next` codes are 0 idle, 1 initial, 2 extended, 3 secondary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new run; latches mode and lane mask |
| mode_tx | input | 1 | 0 receive, 1 transmit (sampled on start) |
| lane_active | input | NUM_LANES | Active-lane mask (sampled on start) |
| word_valid | input | 1 | A status word is present this cycle |
| word_lane | input | LANE_W | Lane the status word belongs to |
| word_data | input | 32 | Search status word |
| pass_end | input | 1 | Current pass finished; a word in the same cycle is ignored |
| pass_next | output | 2 | Pass to run: 0 idle, 1 initial, 2 extended, 3 secondary |
| search_up | output | 1 | Sweep direction for the pass, 1 = low to high |
| iter_count | output | 6 | Iterations for the pass |
| search_first | output | 6 | Start value of the sweep |
| need_secondary | output | 1 | Some active lane is unlocked |
| done | output | 1 | One-cycle pulse at completion |
| rd_lane | input | LANE_W | Lane to read back |
| rd_state | output | 3 | State code of the selected lane |
| rd_shift | output | 6 | Shift value of the selected lane |
| rd_lock | output | 1 | Lock flag of the selected lane |

## Verification
The assertions check on every cycle that the read-back state code is legal and that a failed lane is never shown locked. They also check that `done` is a single-cycle pulse that coincides exactly with the return to idle, that the passes only move forward, that a secondary pass never runs while `need_secondary` is low, and that it always uses 31 iterations. Only the bench scenarios can show the classification itself. That covers the boundary codes that differ between receive and transmit, the direction of the edge adjustment and the min/max choice, reseeding on pass entry, ignored words after an abort or beyond the eighth bit, and the exactly-eight rule that decides the secondary lock.

// File: rtl/lt_pkg.sv
package lt_pkg;

    localparam int WORD_W    = 32;
    localparam int VALID_BIT = 25;
    localparam int RX_CODE_W = 5;
    localparam int TX_CODE_W = 6;
    localparam int CODE_W    = TX_CODE_W;
    localparam int ITER_W    = 6;

    localparam logic [CODE_W-1:0] RX_TOP = CODE_W'((1 << RX_CODE_W) - 1);
    localparam logic [CODE_W-1:0] TX_TOP = CODE_W'((1 << TX_CODE_W) - 1);

    localparam logic [ITER_W-1:0] RX_ITERS  = ITER_W'(31);
    localparam logic [ITER_W-1:0] TX_ITERS  = ITER_W'(63);
    localparam logic [ITER_W-1:0] SEC_ITERS = ITER_W'(31);

    typedef enum logic [2:0] {
        LS_FAIL = 3'd1,
        LS_SEC  = 3'd2,
        LS_INIT = 3'd3,
        LS_EXT  = 3'd4
    } lane_state_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_INIT = 2'd1,
        PH_EXT  = 2'd2,
        PH_SEC  = 2'd3
    } phase_e;

    typedef struct packed {
        logic              ok;
        logic [CODE_W-1:0] code;
    } status_t;

    // Split a raw status word into pass flag and mode-sized edge code.
    function automatic status_t decode(input logic [WORD_W-1:0] w, input logic tx);
        status_t s;
        s.ok   = w[VALID_BIT];
        s.code = w[CODE_W-1:0] & (tx ? TX_TOP : RX_TOP);
        return s;
    endfunction

    function automatic logic at_boundary(input logic [CODE_W-1:0] code, input logic tx);
        return tx ? (code == '0) : (code == RX_TOP);
    endfunction

    // Step the code one tap towards the failing side.
    function automatic logic [CODE_W-1:0] nudge(input logic [CODE_W-1:0] code, input logic tx);
        if (tx)
            return (code == '0) ? '0 : code - 1'b1;
        return code + 1'b1;
    endfunction

    function automatic logic [CODE_W-1:0] low_seed(input logic tx);
        return tx ? TX_TOP : RX_TOP;
    endfunction

endpackage

// File: rtl/lt_lane.sv
module lt_lane
    import lt_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init,
    input  logic              init_tx,
    input  logic              mode_tx,
    input  logic              active,
    input  phase_e            phase,
    input  logic              enter_ext,
    input  logic              enter_sec,
    input  logic              finish_sec,
    input  logic              word_en,
    input  status_t           word,
    output lane_state_e       state,
    output logic              locked,
    output logic [CODE_W-1:0] shift
);

    localparam int CNT_W = $clog2(BITS + 1);

    logic [CNT_W-1:0]  seen;
    logic [CNT_W-1:0]  passes;
    logic [CODE_W-1:0] lo;
    logic [CODE_W-1:0] hi;
    logic              sec_run;
    logic              halted;
    logic [CODE_W-1:0] adj;
    logic              take;
    logic              edge_bad;

    assign adj      = nudge(word.code, mode_tx);
    assign edge_bad = at_boundary(word.code, mode_tx);
    assign take     = word_en && (seen < CNT_W'(BITS));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= LS_INIT;
            locked  <= 1'b1;
            lo      <= RX_TOP;
            hi      <= '0;
            seen    <= '0;
            passes  <= '0;
            sec_run <= 1'b0;
            halted  <= 1'b0;
        end else if (init) begin
            state   <= LS_INIT;
            locked  <= 1'b1;
            lo      <= low_seed(init_tx);
            hi      <= '0;
            seen    <= '0;
            passes  <= '0;
            sec_run <= 1'b0;
            halted  <= 1'b0;
        end else if (enter_ext) begin
            seen <= '0;
            if (state == LS_EXT) begin
                lo <= low_seed(mode_tx);
                hi <= '0;
            end
        end else if (enter_sec) begin
            seen    <= '0;
            passes  <= '0;
            halted  <= 1'b0;
            sec_run <= active && !locked;
            if (active && !locked) begin
                state <= LS_SEC;
                lo    <= low_seed(mode_tx);
                hi    <= '0;
            end
        end else begin
            if (finish_sec && sec_run)
                locked <= (passes == CNT_W'(BITS));
            if (take) begin
                seen <= seen + 1'b1;
                case (phase)
                    PH_INIT: begin
                        if (state == LS_INIT) begin
                            if (!word.ok) begin
                                state  <= LS_FAIL;
                                locked <= 1'b0;
                            end else if (edge_bad) begin
                                state  <= LS_EXT;
                                locked <= 1'b0;
                            end else begin
                                if (adj < lo) lo <= adj;
                                if (adj > hi) hi <= adj;
                            end
                        end
                    end
                    PH_EXT: begin
                        if (state == LS_EXT) begin
                            if (!word.ok || edge_bad) begin
                                state  <= LS_SEC;
                                locked <= 1'b0;
                            end else begin
                                locked <= 1'b1;
                                if (adj < lo) lo <= adj;
                                if (adj > hi) hi <= adj;
                            end
                        end
                    end
                    PH_SEC: begin
                        if (sec_run && !halted) begin
                            if (!word.ok) begin
                                state  <= LS_FAIL;
                                halted <= 1'b1;
                            end else begin
                                passes <= passes + 1'b1;
                                if (adj < lo) lo <= adj;
                                if (adj > hi) hi <= adj;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign shift = mode_tx ? lo : hi;

endmodule

// File: rtl/lt_seq.sv
module lt_seq
    import lt_pkg::*;
#(
    parameter int N = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mode_in,
    input  logic [N-1:0]      act_in,
    input  logic              pass_end,
    input  logic              any_ext,
    input  logic              any_unlocked,
    output phase_e            phase,
    output logic              mode_q,
    output logic [N-1:0]      act_q,
    output logic              enter_ext,
    output logic              enter_sec,
    output logic              finish_sec,
    output logic              done,
    output logic              search_up,
    output logic [ITER_W-1:0] iter_count,
    output logic [ITER_W-1:0] search_first
);

    phase_e nxt;
    logic   advance;

    always_comb begin
        case (phase)
            PH_INIT: nxt = any_ext ? PH_EXT : (any_unlocked ? PH_SEC : PH_IDLE);
            PH_EXT:  nxt = any_unlocked ? PH_SEC : PH_IDLE;
            default: nxt = PH_IDLE;
        endcase
    end

    assign advance    = pass_end && !start && (phase != PH_IDLE);
    assign enter_ext  = advance && (nxt == PH_EXT);
    assign enter_sec  = advance && (nxt == PH_SEC);
    assign finish_sec = advance && (phase == PH_SEC);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            mode_q <= 1'b0;
            act_q  <= '0;
            done   <= 1'b0;
        end else if (start) begin
            phase  <= PH_INIT;
            mode_q <= mode_in;
            act_q  <= act_in;
            done   <= 1'b0;
        end else begin
            done <= advance && (nxt == PH_IDLE);
            if (advance)
                phase <= nxt;
        end
    end

    // Secondary pass sweeps against the initial direction.
    assign search_up    = (phase == PH_SEC) ? !mode_q : mode_q;
    assign iter_count   = (phase == PH_SEC) ? SEC_ITERS : (mode_q ? TX_ITERS : RX_ITERS);
    assign search_first = search_up ? '0 : iter_count;

endmodule

// File: rtl/lane_edge_tracker.sv
module lane_edge_tracker
    import lt_pkg::*;
#(
    parameter int NUM_LANES     = 4,
    parameter int BITS_PER_LANE = 8,
    localparam int LANE_W       = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 mode_tx,
    input  logic [NUM_LANES-1:0] lane_active,
    input  logic                 word_valid,
    input  logic [LANE_W-1:0]    word_lane,
    input  logic [WORD_W-1:0]    word_data,
    input  logic                 pass_end,
    output logic [1:0]           pass_next,
    output logic                 search_up,
    output logic [ITER_W-1:0]    iter_count,
    output logic [ITER_W-1:0]    search_first,
    output logic                 need_secondary,
    output logic                 done,
    input  logic [LANE_W-1:0]    rd_lane,
    output logic [2:0]           rd_state,
    output logic [CODE_W-1:0]    rd_shift,
    output logic                 rd_lock
);

    phase_e               phase;
    logic                 mode_q;
    logic [NUM_LANES-1:0] act_q;
    logic                 enter_ext;
    logic                 enter_sec;
    logic                 finish_sec;
    logic                 any_ext;
    logic                 any_unlocked;
    status_t              word;

    lane_state_e          lane_st  [NUM_LANES];
    logic                 lane_lock[NUM_LANES];
    logic [CODE_W-1:0]    lane_sh  [NUM_LANES];
    logic [NUM_LANES-1:0] ext_vec;
    logic [NUM_LANES-1:0] unl_vec;

    assign word = decode(word_data, mode_q);

    lt_seq #(.N(NUM_LANES)) i_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .mode_in      (mode_tx),
        .act_in       (lane_active),
        .pass_end     (pass_end),
        .any_ext      (any_ext),
        .any_unlocked (any_unlocked),
        .phase        (phase),
        .mode_q       (mode_q),
        .act_q        (act_q),
        .enter_ext    (enter_ext),
        .enter_sec    (enter_sec),
        .finish_sec   (finish_sec),
        .done         (done),
        .search_up    (search_up),
        .iter_count   (iter_count),
        .search_first (search_first)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic en;
        assign en = word_valid && !pass_end && !start && (phase != PH_IDLE)
                    && act_q[g] && (word_lane == LANE_W'(g));

        lt_lane #(.BITS(BITS_PER_LANE)) i_lane (
            .clk        (clk),
            .rst        (rst),
            .init       (start),
            .init_tx    (mode_tx),
            .mode_tx    (mode_q),
            .active     (act_q[g]),
            .phase      (phase),
            .enter_ext  (enter_ext),
            .enter_sec  (enter_sec),
            .finish_sec (finish_sec),
            .word_en    (en),
            .word       (word),
            .state      (lane_st[g]),
            .locked     (lane_lock[g]),
            .shift      (lane_sh[g])
        );

        assign ext_vec[g] = act_q[g] && (lane_st[g] == LS_EXT);
        assign unl_vec[g] = act_q[g] && !lane_lock[g];
    end

    assign any_ext        = |ext_vec;
    assign any_unlocked   = |unl_vec;
    assign need_secondary = any_unlocked;
    assign pass_next      = phase;

    assign rd_state = lane_st[rd_lane];
    assign rd_shift = lane_sh[rd_lane];
    assign rd_lock  = lane_lock[rd_lane];

endmodule

// File: rtl/lt_checker.sv
module lt_checker
    import lt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [1:0]        pass_next,
    input logic [ITER_W-1:0] iter_count,
    input logic              need_secondary,
    input logic              done,
    input logic [2:0]        rd_state,
    input logic              rd_lock
);

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (rd_state >= 3'd1 && rd_state <= 3'd4));                                    // R11

    AST_FAIL_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        (rd_state == LS_FAIL) |-> !rd_lock);                                        // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                                            // R7

    AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (pass_next != PH_IDLE && !start) |=> (done == (pass_next == PH_IDLE)));     // R7

    AST_SEC_FORWARD: assert property (@(posedge clk) disable iff (rst)
        (pass_next == PH_SEC && !start) |=> (pass_next == PH_SEC || pass_next == PH_IDLE)); // R7

    AST_EXT_FORWARD: assert property (@(posedge clk) disable iff (rst)
        (pass_next == PH_EXT && !start) |=> (pass_next != PH_INIT));                // R7

    AST_SEC_NEEDED: assert property (@(posedge clk) disable iff (rst)
        (pass_next == PH_SEC) |-> need_secondary);                                  // R10

    AST_SEC_ITERS: assert property (@(posedge clk) disable iff (rst)
        (pass_next == PH_SEC) |-> (iter_count == SEC_ITERS));                       // R8

endmodule

bind lane_edge_tracker lt_checker i_lt_checker (
    .clk            (clk),
    .rst            (rst),
    .start          (start),
    .pass_next      (pass_next),
    .iter_count     (iter_count),
    .need_secondary (need_secondary),
    .done           (done),
    .rd_state       (rd_state),
    .rd_lock        (rd_lock)
);

// File: tb/test_lane_edge_tracker.sv
`timescale 1ns/1ps
module test_lane_edge_tracker;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        mode_tx = 1'b0;
    logic [3:0]  lane_active = '0;
    logic        word_valid = 1'b0;
    logic [1:0]  word_lane = '0;
    logic [31:0] word_data = '0;
    logic        pass_end = 1'b0;
    logic [1:0]  pass_next;
    logic        search_up;
    logic [5:0]  iter_count;
    logic [5:0]  search_first;
    logic        need_secondary;
    logic        done;
    logic [1:0]  rd_lane = '0;
    logic [2:0]  rd_state;
    logic [5:0]  rd_shift;
    logic        rd_lock;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    lane_edge_tracker i_lane_edge_tracker (
        .clk(clk), .rst(rst), .start(start), .mode_tx(mode_tx),
        .lane_active(lane_active), .word_valid(word_valid), .word_lane(word_lane),
        .word_data(word_data), .pass_end(pass_end), .pass_next(pass_next),
        .search_up(search_up), .iter_count(iter_count), .search_first(search_first),
        .need_secondary(need_secondary), .done(done), .rd_lane(rd_lane),
        .rd_state(rd_state), .rd_shift(rd_shift), .rd_lock(rd_lock)
    );

    typedef struct {
        bit         ctl;
        int         lane;
        logic [2:0] st;
        logic       lk;
        logic [5:0] sh;
        logic [1:0] ph;
        logic       up;
        logic [5:0] it;
        logic [5:0] fs;
        logic       nd;
        logic       dn;
        string      tag;
    } exp_t;

    exp_t q[$];

    // Monitor: pops expected items and compares them away from the clock edge.
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (!e.ctl) begin
                    rd_lane = 2'(e.lane);
                    #1;
                    if ({rd_state, rd_lock, rd_shift} !== {e.st, e.lk, e.sh}) begin
                        errors++;
                        $display("FAIL %s lane %0d state/lock/shift actual %0d/%0d/%0d expected %0d/%0d/%0d",
                                 e.tag, e.lane, rd_state, rd_lock, rd_shift, e.st, e.lk, e.sh);
                    end
                end else begin
                    #1;
                    if ({pass_next, search_up, iter_count, search_first, need_secondary, done}
                        !== {e.ph, e.up, e.it, e.fs, e.nd, e.dn}) begin
                        errors++;
                        $display("FAIL %s pass/up/iter/first/need/done actual %0d/%0d/%0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d/%0d/%0d",
                                 e.tag, pass_next, search_up, iter_count, search_first, need_secondary, done,
                                 e.ph, e.up, e.it, e.fs, e.nd, e.dn);
                    end
                end
            end
        end
    end

    function automatic logic [31:0] vw(input int code);
        return 32'h0200_0000 | 32'(code);
    endfunction

    function automatic logic [31:0] iv(input int code);
        return 32'(code);
    endfunction

    task automatic exp_lane(input int lane, input int st, input int lk, input int sh, input string tag);
        exp_t e;
        e.ctl = 0; e.lane = lane; e.st = 3'(st); e.lk = lk[0]; e.sh = 6'(sh);
        e.ph = '0; e.up = 0; e.it = '0; e.fs = '0; e.nd = 0; e.dn = 0; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic exp_ctl(input int ph, input int up, input int it, input int fs,
                           input int nd, input int dn, input string tag);
        exp_t e;
        e.ctl = 1; e.lane = 0; e.st = '0; e.lk = 0; e.sh = '0;
        e.ph = 2'(ph); e.up = up[0]; e.it = 6'(it); e.fs = 6'(fs); e.nd = nd[0]; e.dn = dn[0];
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic flush();
        while (q.size() != 0) @(negedge clk);
        #3;
    endtask

    task automatic do_start(input bit tx, input logic [3:0] mask);
        start = 1'b1; mode_tx = tx; lane_active = mask;
        @(posedge clk); #2;
        start = 1'b0;
    endtask

    task automatic send(input int lane, input logic [31:0] data);
        word_valid = 1'b1; word_lane = 2'(lane); word_data = data;
        @(posedge clk); #2;
        word_valid = 1'b0;
    endtask

    task automatic end_pass();
        pass_end = 1'b1;
        @(posedge clk); #2;
        pass_end = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        exp_lane(0, 3, 1, 0, "R1 reset");
        exp_ctl(0, 0, 31, 31, 0, 0, "R1 reset");
        flush();

        // ---------- Scenario A: receive, all lanes, all three passes ----------
        do_start(1'b0, 4'hF);
        exp_ctl(1, 0, 31, 31, 0, 0, "R1 rx start");
        flush();
        begin
            int e0[8] = '{10, 11, 12, 13, 9, 8, 14, 10};
            foreach (e0[i]) send(0, vw(e0[i]));
        end
        send(1, iv(3));
        send(1, vw(4));
        send(2, vw(5));
        send(2, vw(6));
        send(2, vw(31));
        send(2, vw(2));
        for (int i = 0; i < 8; i++) send(3, vw(20));
        exp_lane(0, 3, 1, 15, "R4 rx max");
        exp_lane(1, 1, 0, 0, "R3 rx invalid");
        exp_lane(2, 4, 0, 7, "R3 rx boundary");
        exp_lane(3, 3, 1, 21, "R4 rx +1");
        exp_ctl(1, 0, 31, 31, 1, 0, "R10 unlocked");
        flush();
        end_pass();
        exp_ctl(2, 0, 31, 31, 1, 0, "R7 to extended");
        exp_lane(2, 4, 0, 0, "R5 reseed");
        flush();
        for (int i = 3; i <= 10; i++) send(2, vw(i));
        send(0, vw(30));
        exp_lane(2, 4, 1, 11, "R5 relock");
        exp_lane(0, 3, 1, 15, "R5 non-ext ignored");
        flush();
        end_pass();
        exp_ctl(3, 1, 31, 0, 1, 0, "R8 rx reversed");
        exp_lane(1, 2, 0, 0, "R6 enter secondary");
        flush();
        for (int i = 0; i < 8; i++) send(1, vw(2));
        send(0, vw(1));
        exp_lane(1, 2, 0, 3, "R6 lock waits for end");
        exp_lane(0, 3, 1, 15, "R6 locked lane ignored");
        flush();
        end_pass();
        exp_ctl(0, 0, 31, 31, 0, 1, "R7 done");
        exp_lane(1, 2, 1, 3, "R6 eight passes lock");
        exp_lane(2, 4, 1, 11, "R5 kept");
        flush();

        // ---------- Scenario B: transmit, lanes 0 and 2 active ----------
        do_start(1'b1, 4'b0101);
        exp_ctl(1, 1, 63, 0, 0, 0, "R1 tx start");
        exp_lane(0, 3, 1, 63, "R1 tx seed");
        flush();
        begin
            int e0[8] = '{40, 35, 50, 45, 41, 36, 60, 38};
            foreach (e0[i]) send(0, vw(e0[i]));
        end
        send(1, iv(3));
        send(2, vw(0));
        exp_lane(0, 3, 1, 34, "R4 tx min");
        exp_lane(1, 3, 1, 63, "R9 inactive lane");
        exp_lane(2, 4, 0, 63, "R3 tx boundary");
        flush();
        end_pass();
        exp_ctl(2, 1, 63, 0, 1, 0, "R7 tx extended");
        flush();
        send(2, vw(20));
        exp_lane(2, 4, 1, 19, "R5 tx relock");
        flush();
        send(2, iv(7));
        exp_lane(2, 2, 0, 19, "R5 invalid");
        flush();
        send(2, vw(5));
        exp_lane(2, 2, 0, 19, "R5 after abort ignored");
        flush();
        end_pass();
        exp_ctl(3, 0, 31, 31, 1, 0, "R8 tx reversed");
        exp_lane(2, 2, 0, 63, "R6 tx reseed");
        flush();
        send(2, vw(0));
        exp_lane(2, 2, 0, 0, "R4 tx floor at 0");
        flush();
        for (int i = 0; i < 6; i++) send(2, vw(10));
        send(2, iv(1));
        exp_lane(2, 1, 0, 0, "R6 secondary fail");
        flush();
        end_pass();
        exp_ctl(0, 1, 63, 0, 1, 1, "R7 tx done");
        exp_lane(2, 1, 0, 0, "R6 stays unlocked");
        exp_lane(0, 3, 1, 34, "R4 tx kept");
        flush();

        // ---------- Scenario C: receive, all pass, direct completion ----------
        do_start(1'b0, 4'hF);
        for (int i = 0; i < 8; i++) send(0, vw(5));
        send(0, vw(29));
        send(1, 32'h0200_0025);
        send(2, vw(5));
        send(3, vw(5));
        exp_lane(0, 3, 1, 6, "R9 ninth word ignored");
        exp_lane(1, 3, 1, 6, "R2 field width");
        flush();
        end_pass();
        exp_ctl(0, 0, 31, 31, 0, 1, "R7 direct done");
        flush();

        // ---------- Scenario D: receive, fail skips extended, seven passes ----------
        do_start(1'b0, 4'b0001);
        send(0, iv(0));
        send(1, vw(31));
        exp_lane(1, 3, 1, 0, "R9 inactive boundary ignored");
        flush();
        end_pass();
        exp_ctl(3, 1, 31, 0, 1, 0, "R7 skip extended");
        flush();
        for (int i = 0; i < 7; i++) send(0, vw(4));
        end_pass();
        exp_ctl(0, 0, 31, 31, 1, 1, "R7 done after secondary");
        exp_lane(0, 2, 0, 5, "R6 seven passes stay unlocked");
        flush();

        finished = 1;
        summary();
    end

endmodule